// File: doc/BRIEF.md
# IDE Configuration Unlock Snooper

This block sits on the host side of an IDE task-file and control-block decode and watches every host register access. A fixed, ordered chain of plain register reads, opened by a host write that sets bit 7 of the sector-count register, switches the controller into a hidden programming mode. Software tests for the controller by reading sector count afterwards: bit 7 comes back cleared.

While programming mode is active, three task-file addresses stop reaching the drive and act as controller configuration registers instead. The sector-number address holds the PIO speed codes for both drives. The low-cylinder address holds the per-drive extra speed bit, the per-drive IORDY enables and an enable for an extra index register. The index register appears at the drive/head address. A read of the high-cylinder register leaves the mode. The configuration values drive the per-drive speed and IORDY outputs, which feed the strobe timing generator elsewhere in the chip.

Host addresses are 4 bits wide. Bit 3 selects the control block and bits 2:0 give the register offset. Offsets 0 to 7 are task-file registers, and 4'hE is the alternate status register.

Top module: `ide_cfg_unlock`

## Requirements
- R1: After reset, programming mode is off, the extra index register is disabled, both speed outputs are 0 (PIO 0) and both IORDY outputs are 0.
- R2: A host write of sector count (4'h2) with bit 7 set arms the tracker. The chain that follows is six reads in this order: high cylinder (4'h5), sector count (4'h2), alternate status (4'hE) twice, then sector count twice.
- R3: The sixth chain read completes the unlock. `prog_mode` is 1 from the following cycle, and the completing read itself returns the drive's data unchanged.
- R4: Once the tracker is armed, any write or any read of an address other than the expected one returns it to idle, and the remaining reads of the chain do not enter programming mode. The one exception is a write of sector count with bit 7 set, which re-arms the tracker.
- R5: After an unlock, every host read of sector count returns bit 7 as 0, inside and outside programming mode. This lasts until the host next writes sector count.
- R6: In programming mode, a host read of high cylinder (4'h5) is passed to the drive and turns `prog_mode` off from the following cycle.
- R7: In programming mode, address 4'h3 is the speed register. The slave code sits in bits 2:0 and the master code in bits 5:3. Codes are 0 for PIO 0, 4 for PIO 1 and 7 for PIO 2. Bit 7 reads back as 1 whenever either code is 7, and otherwise as written.
- R8: In programming mode, address 4'h4 is the mode register. Bit 0 enables the extra index register. Bit 5 is the master extra speed bit and bit 3 the master IORDY enable. Bit 4 is the slave extra speed bit and bit 2 the slave IORDY enable. Each speed output is {extra bit, 3-bit code}.
- R9: In programming mode, with bit 0 of the mode register set, address 4'h6 is the index register and a value written there reads back unchanged. With bit 0 clear, 4'h6 goes to the drive.
- R10: Outside programming mode, every host access is forwarded to the drive unchanged, and the configuration registers keep their values.
- R11: In programming mode, an access to a configuration register does not reach the drive, and the drive's copy of that register is left untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 4 | Host register address: {control block, offset} |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data |
| d_rd | output | 1 | Read strobe forwarded to the drive |
| d_wr | output | 1 | Write strobe forwarded to the drive |
| d_rdata | input | 8 | Read data from the drive |
| prog_mode | output | 1 | Programming mode active |
| mst_speed | output | 4 | Master speed: {extra bit, code} |
| slv_speed | output | 4 | Slave speed: {extra bit, code} |
| mst_iordy | output | 1 | Master IORDY enable |
| slv_iordy | output | 1 | Slave IORDY enable |

## Verification
The sixth chain read both completes the unlock and returns sector-count data. The bench checks that this read still shows bit 7 set, and that only the next sector-count read shows it cleared. The mode-register write that sets the index enable can also fall next to an index access. The bench writes the enable, then confirms that the index address is claimed only from the next access onward, after an earlier drive-bound write to that same address.

// File: rtl/ide_unlock_pkg.sv
package ide_unlock_pkg;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int SPD_W = 3;
  localparam int SPD_POS_M = 3;

  localparam logic [AW-1:0] A_SC  = 4'h2;
  localparam logic [AW-1:0] A_SN  = 4'h3;
  localparam logic [AW-1:0] A_LC  = 4'h4;
  localparam logic [AW-1:0] A_HC  = 4'h5;
  localparam logic [AW-1:0] A_IDX = 4'h6;
  localparam logic [AW-1:0] A_AS  = 4'hE;

  localparam int LC_EN   = 0;
  localparam int LC_SIOR = 2;
  localparam int LC_MIOR = 3;
  localparam int LC_SEXT = 4;
  localparam int LC_MEXT = 5;

  localparam logic [SPD_W-1:0] SPD_TOP = '1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_C1, ST_C2, ST_C3, ST_C4, ST_C5, ST_PROG
  } seq_t;
endpackage

// File: rtl/ide_rst_sync.sv
module ide_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/ide_unlock_seq.sv
module ide_unlock_seq
  import ide_unlock_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          prog,
  output logic          sc_clr
);
  seq_t st_q, st_d;
  logic sc_clr_q, sc_clr_d;
  logic st_en;

  function automatic logic [AW-1:0] expect_addr(input seq_t s);
    case (s)
      ST_ARMED: expect_addr = A_HC;
      ST_C1:    expect_addr = A_SC;
      ST_C2:    expect_addr = A_AS;
      ST_C3:    expect_addr = A_AS;
      default:  expect_addr = A_SC;
    endcase
  endfunction

  assign st_en = rd | wr;

  always_comb begin
    st_d = st_q;
    if (st_q == ST_PROG) begin
      if (rd && addr == A_HC) st_d = ST_IDLE;
    end else if (wr) begin
      st_d = (addr == A_SC && wdata[DW-1]) ? ST_ARMED : ST_IDLE;
    end else if (rd && st_q != ST_IDLE) begin
      if (addr != expect_addr(st_q)) st_d = ST_IDLE;
      else if (st_q == ST_C5)        st_d = ST_PROG;
      else                           st_d = seq_t'(st_q + 3'd1);
    end
  end

  always_comb begin
    sc_clr_d = sc_clr_q;
    if (wr && addr == A_SC)                            sc_clr_d = 1'b0;
    else if (st_q == ST_C5 && st_d == ST_PROG)         sc_clr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sc_clr_q <= 1'b0;
    end else if (st_en) begin
      st_q     <= st_d;
      sc_clr_q <= sc_clr_d;
    end
  end

  assign prog   = (st_q == ST_PROG);
  assign sc_clr = sc_clr_q;
endmodule

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
  import ide_unlock_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          claim,
  output logic [DW-1:0] cfg_rdata,
  output logic [SPD_W:0] mst_speed,
  output logic [SPD_W:0] slv_speed,
  output logic          mst_iordy,
  output logic          slv_iordy
);
  logic [DW-1:0] sn_q, sn_d, lc_q, ix_q;
  logic sel_sn, sel_lc, sel_ix;
  logic sn_en, lc_en, ix_en;
  logic top_code;

  assign sel_sn = prog && addr == A_SN;
  assign sel_lc = prog && addr == A_LC;
  assign sel_ix = prog && lc_q[LC_EN] && addr == A_IDX;
  assign claim  = sel_sn | sel_lc | sel_ix;

  assign sn_en = sel_sn & wr;
  assign lc_en = sel_lc & wr;
  assign ix_en = sel_ix & wr;

  assign top_code = (wdata[SPD_W-1:0] == SPD_TOP) ||
                    (wdata[SPD_POS_M +: SPD_W] == SPD_TOP);

  always_comb begin
    sn_d = wdata;
    sn_d[DW-1] = wdata[DW-1] | top_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sn_q <= '0;
      lc_q <= '0;
      ix_q <= '0;
    end else begin
      if (sn_en) sn_q <= sn_d;
      if (lc_en) lc_q <= wdata;
      if (ix_en) ix_q <= wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (rd) begin
      if (sel_sn)      cfg_rdata = sn_q;
      else if (sel_lc) cfg_rdata = lc_q;
      else if (sel_ix) cfg_rdata = ix_q;
    end
  end

  assign mst_speed = {lc_q[LC_MEXT], sn_q[SPD_POS_M +: SPD_W]};
  assign slv_speed = {lc_q[LC_SEXT], sn_q[SPD_W-1:0]};
  assign mst_iordy = lc_q[LC_MIOR];
  assign slv_iordy = lc_q[LC_SIOR];
endmodule

// File: rtl/ide_cfg_unlock.sv
module ide_cfg_unlock
  import ide_unlock_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    h_addr,
  input  logic          h_rd,
  input  logic          h_wr,
  input  logic [7:0]    h_wdata,
  output logic [7:0]    h_rdata,
  output logic          d_rd,
  output logic          d_wr,
  input  logic [7:0]    d_rdata,
  output logic          prog_mode,
  output logic [3:0]    mst_speed,
  output logic [3:0]    slv_speed,
  output logic          mst_iordy,
  output logic          slv_iordy
);
  logic rst_n_s;
  logic prog, sc_clr, claim;
  logic [DW-1:0] cfg_rdata, drv_view;

  ide_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  ide_unlock_seq u_seq (
    .clk(clk), .rst_n(rst_n_s), .addr(h_addr), .rd(h_rd), .wr(h_wr),
    .wdata(h_wdata), .prog(prog), .sc_clr(sc_clr)
  );

  ide_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n_s), .prog(prog), .addr(h_addr), .rd(h_rd),
    .wr(h_wr), .wdata(h_wdata), .claim(claim), .cfg_rdata(cfg_rdata),
    .mst_speed(mst_speed), .slv_speed(slv_speed),
    .mst_iordy(mst_iordy), .slv_iordy(slv_iordy)
  );

  always_comb begin
    drv_view = d_rdata;
    if (sc_clr && h_addr == A_SC) drv_view[DW-1] = 1'b0;
  end

  assign d_rd      = h_rd & ~claim;
  assign d_wr      = h_wr & ~claim;
  assign h_rdata   = claim ? cfg_rdata : drv_view;
  assign prog_mode = prog;
endmodule

// File: rtl/ide_cfg_unlock_chk.sv
module ide_cfg_unlock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] h_addr,
  input logic       h_rd,
  input logic       h_wr,
  input logic [7:0] h_rdata,
  input logic       d_rd,
  input logic       d_wr,
  input logic       prog_mode,
  input logic [3:0] mst_speed,
  input logic [3:0] slv_speed,
  input logic       mst_iordy,
  input logic       slv_iordy
);
  assert_enter_on_sc_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_mode) |-> $past(h_rd && h_addr == 4'h2));

  assert_exit_on_hc_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_mode) |-> $past(h_rd && h_addr == 4'h5));

  assert_speed_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && h_rd && h_addr == 4'h3 && h_rdata[2:0] == 3'd7) |-> h_rdata[7]);

  assert_pass_through_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |-> (d_rd == h_rd && d_wr == h_wr));

  assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |=> $stable({mst_speed, slv_speed, mst_iordy, slv_iordy}));

  assert_cfg_hidden_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && (h_addr == 4'h3 || h_addr == 4'h4)) |-> (!d_rd && !d_wr));
endmodule

bind ide_cfg_unlock ide_cfg_unlock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
  .h_rdata(h_rdata), .d_rd(d_rd), .d_wr(d_wr), .prog_mode(prog_mode),
  .mst_speed(mst_speed), .slv_speed(slv_speed),
  .mst_iordy(mst_iordy), .slv_iordy(slv_iordy)
);

// File: tb/ide_cfg_unlock_bench.sv
`timescale 1ns/1ps
module ide_cfg_unlock_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] h_addr;
  logic       h_rd, h_wr;
  logic [7:0] h_wdata, h_rdata, d_rdata;
  logic       d_rd, d_wr, prog_mode, mst_iordy, slv_iordy;
  logic [3:0] mst_speed, slv_speed;
  logic [7:0] tf [8];
  int checks = 0;
  int fails  = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  ide_cfg_unlock u_ide_cfg_unlock (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .d_rd(d_rd), .d_wr(d_wr),
    .d_rdata(d_rdata), .prog_mode(prog_mode), .mst_speed(mst_speed),
    .slv_speed(slv_speed), .mst_iordy(mst_iordy), .slv_iordy(slv_iordy)
  );

  // simple drive model: task file storage, fixed alternate status
  assign d_rdata = h_addr[3] ? 8'h50 : tf[h_addr[2:0]];
  always @(posedge clk) if (d_wr && !h_addr[3]) tf[h_addr[2:0]] <= h_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1; h_rd = 1'b0;
    @(posedge clk);
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); h_addr = a; h_rd = 1'b1; h_wr = 1'b0;
    #1 d = h_rdata;
    @(posedge clk);
    @(negedge clk); h_rd = 1'b0;
  endtask

  task automatic chain();
    logic [7:0] t;
    rd(4'h5, t); rd(4'h2, t); rd(4'hE, t); rd(4'hE, t); rd(4'h2, t); rd(4'h2, t);
  endtask

  task automatic t_reset();
    chk("R1 prog", prog_mode, 0);
    chk("R1 speeds", {mst_speed, slv_speed}, 0);
    chk("R1 iordy", {mst_iordy, slv_iordy}, 0);
  endtask

  task automatic t_break();
    logic [7:0] t;
    wr(4'h2, 8'h81);
    rd(4'h5, t); rd(4'h2, t);
    wr(4'h1, 8'h00);              // write breaks the chain
    rd(4'hE, t); rd(4'hE, t); rd(4'h2, t); rd(4'h2, t);
    @(negedge clk); chk("R4 write break", prog_mode, 0);
    wr(4'h2, 8'h81);
    rd(4'h5, t); rd(4'h2, t); rd(4'hE, t);
    rd(4'h7, t);                  // wrong address
    rd(4'hE, t); rd(4'h2, t); rd(4'h2, t);
    @(negedge clk); chk("R4 addr break", prog_mode, 0);
    rd(4'h2, t); chk("R4 sc bit7 kept", t, 8'h81);
  endtask

  task automatic t_unlock();
    logic [7:0] t;
    wr(4'h2, 8'h81);
    rd(4'h5, t); rd(4'h2, t); rd(4'hE, t); rd(4'hE, t); rd(4'h2, t);
    chk("R2 not yet", prog_mode, 0);
    rd(4'h2, t);
    chk("R3 completing read unmasked", t, 8'h81);
    @(negedge clk); chk("R3 prog on", prog_mode, 1);
    rd(4'h2, t); chk("R5 sc bit7 cleared", t, 8'h01);
  endtask

  task automatic t_config();
    logic [7:0] t;
    wr(4'h6, 8'hB0);              // index disabled: goes to drive
    wr(4'h3, 8'h3C);
    rd(4'h3, t); chk("R7 speed readback", t, 8'hBC);
    chk("R7 master code", mst_speed, 4'h7);
    chk("R7 slave code", slv_speed, 4'h4);
    wr(4'h4, 8'h29);
    rd(4'h4, t); chk("R8 mode readback", t, 8'h29);
    chk("R8 master ext+iordy", {mst_speed, mst_iordy, slv_iordy}, {4'hF, 1'b1, 1'b0});
    wr(4'h6, 8'h5A);
    rd(4'h6, t); chk("R9 index readback", t, 8'h5A);
    wr(4'h4, 8'h15);              // slave bits, enable kept
    chk("R8 slave ext+iordy", {slv_speed, slv_iordy, mst_iordy}, {4'hC, 1'b1, 1'b0});
  endtask

  task automatic t_exit();
    logic [7:0] t;
    rd(4'h5, t);
    @(negedge clk); chk("R6 prog off", prog_mode, 0);
    rd(4'h3, t); chk("R11 drive sn untouched", t, 8'h11);
    rd(4'h6, t); chk("R9 disabled index went to drive", t, 8'hB0);
    wr(4'h3, 8'h00);
    chk("R10 cfg kept", {mst_speed, slv_speed}, {4'h7, 4'hC});
    rd(4'h3, t); chk("R10 forwarded write", t, 8'h00);
    rd(4'h2, t); chk("R5 still masked outside", t, 8'h01);
    wr(4'h2, 8'h81);
    rd(4'h2, t); chk("R5 cleared by write", t, 8'h81);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) tf[i] = 8'h00;
    tf[3] = 8'h11;
    rst_n = 1'b0; h_addr = '0; h_rd = 0; h_wr = 0; h_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_break();
    t_unlock();
    t_config();
    t_exit();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule